// File: doc/BRIEF.md
# Node Admission Policy Evaluator

This block decides whether a processing node that has passed or failed its component self-tests may join the system, and which of its parts may be connected. It watches six pass/fail results: one for each of four link transceivers, one for the routing-setup (configuration) logic and one for the compute logic. These results arrive as status inputs together with a single-cycle valid strobe. When the strobe is high, the block applies a tolerance policy chosen by a 3-bit selector and registers its verdict.

The verdict is a node-enable flag, a compute-enable flag and one enable per transceiver. It also includes a flag that reports when more than two transceivers are down. The policies differ in how many dead transceivers they accept and in whether a dead compute unit is acceptable. One hybrid policy admits a node that can still compute on a single link, and also admits a node that can only relay traffic between two working links. A component that has failed, or has not been tested yet, is never enabled.

Top module: `node_admit`

## Requirements
- R1: After reset, and until the first cycle in which `statusValid` is high, every output is 0.
- R2: Outputs change only on a rising clock edge at which `statusValid` is high. Between strobes they hold their value, whatever the other inputs do.
- R3: When `cfgOk` is 0 at the strobe, `nodeEnable` is 0 under every policy.
- R4: Policy 0 (strict) enables the node only if `cfgOk`, `computeOk` and all four `xcvrOk` bits are 1.
- R5: Policy 1 enables the node if `cfgOk` and `computeOk` are 1 and at least two `xcvrOk` bits are 1.
- R6: Policy 2 enables the node if `cfgOk` and `computeOk` are 1 and at least one `xcvrOk` bit is 1.
- R7: Policy 3 enables the node if `cfgOk` is 1 and at least two `xcvrOk` bits are 1. The value of `computeOk` does not matter to acceptance.
- R8: Policy 4 (hybrid) enables the node if the condition of policy 2 holds, or if the condition of policy 3 holds.
- R9: Policy values 5, 6 and 7 behave exactly like policy 0.
- R10: When the node is enabled, `computeEnable` equals `computeOk` and `xcvrEnable[i]` equals `xcvrOk[i]`. When the node is disabled, both are all zero.
- R11: `linkShortage` is registered on the strobe. It is 1 exactly when three or more `xcvrOk` bits are 0, and this holds under any policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| statusValid | input | 1 | Strobe: status inputs are valid this cycle |
| xcvrOk | input | 4 | Per-transceiver test pass bits |
| cfgOk | input | 1 | Configuration logic test pass |
| computeOk | input | 1 | Compute logic test pass |
| policySel | input | 3 | Tolerance policy selector (0..4, others act as 0) |
| nodeEnable | output | 1 | Node admitted to the system |
| computeEnable | output | 1 | Compute logic connected |
| xcvrEnable | output | 4 | Per-transceiver connect enables |
| linkShortage | output | 1 | More than two transceivers failed |

## Verification
The checker verifies the following on every cycle:
- Outputs hold between strobes.
- A failed configuration or compute test suppresses the node in the policies that require that component.
- No transceiver or compute enable is ever high while the node is disabled.
- The shortage flag follows the count of failed links.

The exact acceptance boundary of each policy is shown only by the bench. It walks every combination of link results, configuration result, compute result and selector value, including the three reserved selector codes. It also checks that inputs which change without a strobe leave the outputs untouched.

// File: rtl/node_admit_pkg.sv
package node_admit_pkg;
  typedef enum logic [2:0] {
    POL_STRICT  = 3'd0,
    POL_LINK2   = 3'd1,
    POL_LINK1   = 3'd2,
    POL_RELAY   = 3'd3,
    POL_EITHER  = 3'd4
  } policyT;

  typedef struct packed {
    logic load;
    logic accept;
  } ctrlStrobeT;
endpackage

// File: rtl/node_admit_ctrl.sv
module node_admit_ctrl
  import node_admit_pkg::*;
#(
  parameter int NUM_XCVR = 4,
  parameter int MIN_LINKS_COMPUTE = 1,
  parameter int MIN_LINKS_RELAY = 2,
  parameter int MIN_LINKS_T2 = 2,
  localparam int CNT_W = $clog2(NUM_XCVR + 1)
) (
  input  logic             statusValid,
  input  logic             cfgOk,
  input  logic             computeOk,
  input  logic [2:0]       policySel,
  input  logic [CNT_W-1:0] goodCount,
  output ctrlStrobeT       strobes
);
  logic allLinks;
  logic computeNode;
  logic t2Node;
  logic relayNode;
  logic acceptNow;

  always_comb begin
    allLinks    = goodCount == CNT_W'(NUM_XCVR);
    computeNode = cfgOk && computeOk && (goodCount >= CNT_W'(MIN_LINKS_COMPUTE));
    t2Node      = cfgOk && computeOk && (goodCount >= CNT_W'(MIN_LINKS_T2));
    relayNode   = cfgOk && (goodCount >= CNT_W'(MIN_LINKS_RELAY));
    case (policyT'(policySel))
      POL_LINK2:  acceptNow = t2Node;
      POL_LINK1:  acceptNow = computeNode;
      POL_RELAY:  acceptNow = relayNode;
      POL_EITHER: acceptNow = computeNode || relayNode;
      default:    acceptNow = cfgOk && computeOk && allLinks;
    endcase
    strobes.load   = statusValid;
    strobes.accept = acceptNow;
  end
endmodule

// File: rtl/node_admit_dp.sv
module node_admit_dp
  import node_admit_pkg::*;
#(
  parameter int NUM_XCVR = 4,
  parameter int MAX_FAILED_OK = 2,
  localparam int CNT_W = $clog2(NUM_XCVR + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobeT          strobes,
  input  logic [NUM_XCVR-1:0] xcvrOk,
  input  logic                computeOk,
  output logic [CNT_W-1:0]    goodCount,
  output logic                nodeEnable,
  output logic                computeEnable,
  output logic [NUM_XCVR-1:0] xcvrEnable,
  output logic                linkShortage
);
  localparam int SHORT_BELOW = NUM_XCVR - MAX_FAILED_OK;

  always_comb begin
    goodCount = '0;
    for (int i = 0; i < NUM_XCVR; i++) begin
      goodCount = goodCount + CNT_W'(xcvrOk[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nodeEnable    <= 1'b0;
      computeEnable <= 1'b0;
      xcvrEnable    <= '0;
      linkShortage  <= 1'b0;
    end else if (strobes.load) begin
      nodeEnable    <= strobes.accept;
      computeEnable <= strobes.accept && computeOk;
      xcvrEnable    <= strobes.accept ? xcvrOk : '0;
      linkShortage  <= goodCount < CNT_W'(SHORT_BELOW);
    end
  end
endmodule

// File: rtl/node_admit.sv
module node_admit
  import node_admit_pkg::*;
#(
  parameter int NUM_XCVR = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                statusValid,
  input  logic [NUM_XCVR-1:0] xcvrOk,
  input  logic                cfgOk,
  input  logic                computeOk,
  input  logic [2:0]          policySel,
  output logic                nodeEnable,
  output logic                computeEnable,
  output logic [NUM_XCVR-1:0] xcvrEnable,
  output logic                linkShortage
);
  localparam int CNT_W = $clog2(NUM_XCVR + 1);

  ctrlStrobeT       strobes;
  logic [CNT_W-1:0] goodCount;

  node_admit_ctrl #(.NUM_XCVR(NUM_XCVR)) ctrlInst (
    .statusValid(statusValid),
    .cfgOk(cfgOk),
    .computeOk(computeOk),
    .policySel(policySel),
    .goodCount(goodCount),
    .strobes(strobes)
  );

  node_admit_dp #(.NUM_XCVR(NUM_XCVR)) dpInst (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .xcvrOk(xcvrOk),
    .computeOk(computeOk),
    .goodCount(goodCount),
    .nodeEnable(nodeEnable),
    .computeEnable(computeEnable),
    .xcvrEnable(xcvrEnable),
    .linkShortage(linkShortage)
  );
endmodule

// File: rtl/node_admit_chk.sv
module node_admit_chk #(
  parameter int NUM_XCVR = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                statusValid,
  input logic [NUM_XCVR-1:0] xcvrOk,
  input logic                cfgOk,
  input logic                computeOk,
  input logic [2:0]          policySel,
  input logic                nodeEnable,
  input logic                computeEnable,
  input logic [NUM_XCVR-1:0] xcvrEnable,
  input logic                linkShortage
);
  // R2
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statusValid |=> $stable({nodeEnable, computeEnable, xcvrEnable, linkShortage}));

  // R3
  cfg_fail_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusValid && !cfgOk |=> !nodeEnable);

  // R4
  strict_needs_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusValid && policySel == 3'd0 && !(&xcvrOk) |=> !nodeEnable);

  // R6
  link1_needs_compute_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusValid && policySel == 3'd2 && !computeOk |=> !nodeEnable);

  // R10
  disabled_isolates_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nodeEnable |-> (xcvrEnable == '0) && !computeEnable);

  // R11
  shortage_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |=> linkShortage == ($countones($past(xcvrOk)) < NUM_XCVR - 2));
endmodule

bind node_admit node_admit_chk #(.NUM_XCVR(NUM_XCVR)) chkInst (
  .clk(clk),
  .rstN(rstN),
  .statusValid(statusValid),
  .xcvrOk(xcvrOk),
  .cfgOk(cfgOk),
  .computeOk(computeOk),
  .policySel(policySel),
  .nodeEnable(nodeEnable),
  .computeEnable(computeEnable),
  .xcvrEnable(xcvrEnable),
  .linkShortage(linkShortage)
);

// File: tb/node_admit_test.sv
module node_admit_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       statusValid = 1'b0;
  logic [3:0] xcvrOk = 4'h0;
  logic       cfgOk = 1'b0;
  logic       computeOk = 1'b0;
  logic [2:0] policySel = 3'd0;
  logic       nodeEnable, computeEnable, linkShortage;
  logic [3:0] xcvrEnable;

  int compared = 0;
  int mismatched = 0;

  // reference state
  int expNode = 0, expComp = 0, expXcvr = 0, expShort = 0;

  always #4 clk = ~clk;

  node_admit uut (
    .clk(clk), .rstN(rstN), .statusValid(statusValid), .xcvrOk(xcvrOk),
    .cfgOk(cfgOk), .computeOk(computeOk), .policySel(policySel),
    .nodeEnable(nodeEnable), .computeEnable(computeEnable),
    .xcvrEnable(xcvrEnable), .linkShortage(linkShortage)
  );

  function automatic int countOnes(int v);
    int n = 0;
    for (int i = 0; i < 4; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic int verdict(int links, int cfg, int comp, int pol);
    int good = countOnes(links);
    if (cfg == 0) return 0;
    case (pol)
      1: return (comp != 0 && good >= 2) ? 1 : 0;
      2: return (comp != 0 && good >= 1) ? 1 : 0;
      3: return (good >= 2) ? 1 : 0;
      4: return ((comp != 0 && good >= 1) || good >= 2) ? 1 : 0;
      default: return (comp != 0 && good == 4) ? 1 : 0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compareAll(string nodeTag);
    check(nodeTag, int'(nodeEnable), expNode);
    check("R10 compute", int'(computeEnable), expComp);
    check("R10 links", int'(xcvrEnable), expXcvr);
    check("R11", int'(linkShortage), expShort);
  endtask

  // drive at negedge, clock through, update model, compare at next negedge
  task automatic step(int v, int links, int cfg, int comp, int pol, string tag);
    statusValid = v[0];
    xcvrOk = links[3:0];
    cfgOk = cfg[0];
    computeOk = comp[0];
    policySel = pol[2:0];
    @(posedge clk);
    if (v != 0) begin
      expNode  = verdict(links, cfg, comp, pol);
      expComp  = expNode != 0 ? comp : 0;
      expXcvr  = expNode != 0 ? links : 0;
      expShort = countOnes(links) < 2 ? 1 : 0;
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  function automatic string tagFor(int cfg, int pol);
    if (cfg == 0) return "R3";
    case (pol)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  logic finished = 1'b0;

  initial begin
    #(8 * 100000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compareAll("R1 in reset");
    rstN = 1'b1;
    // R1: inputs all passing but no strobe yet
    for (int k = 0; k < 3; k++) step(0, 15, 1, 1, 4, "R1");
    // R2: strobe an accepted node, then wiggle inputs without strobe
    step(1, 15, 1, 1, 0, "R4");
    step(0, 0, 0, 0, 0, "R2");
    step(0, 1, 1, 0, 3, "R2");
    step(1, 1, 1, 0, 3, "R7");
    step(0, 15, 1, 1, 0, "R2");
    // exhaustive sweep of every status and selector combination
    for (int pol = 0; pol < 8; pol++)
      for (int cfg = 0; cfg < 2; cfg++)
        for (int comp = 0; comp < 2; comp++)
          for (int links = 0; links < 16; links++) begin
            step(1, links, cfg, comp, pol, tagFor(cfg, pol));
            if (links == 7) step(0, 15 - links, 1 - cfg, 1 - comp, 4, "R2");
          end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule